// File: doc/BRIEF.md
# DSP Multiply-Accumulate Engine

This block is the arithmetic core of a signal-processing datapath. Each cycle it can take two 16-bit operands and one command. It forms a 17x17 product, then either loads the product into one of two 40-bit accumulators or adds it to, or subtracts it from, that accumulator. It can also add one accumulator to another, subtract one from another, or move an accumulator left or right by up to 16 places. The operands can be signed (two's complement) or unsigned, and can be read as integers or as fractions. A fractional product is doubled before it is used, so that the extra sign bit drops out.

Each accumulator has 8 guard bits above a 32-bit working range. A per-accumulator flag shows when those guard bits are in use. When saturation is enabled for a command, a result that does not fit in 40 bits is clamped to the nearest 40-bit limit, and a sticky flag records that the clamp happened. When saturation is disabled, the result wraps. A command presented with `op_valid` high is written into the destination accumulator at the next rising clock edge. It is visible on `acc_out` right after that edge.

Top module: `dsp_mac_engine`

## Requirements
- R1: After a synchronous active-low reset, both accumulators are zero and every overflow and saturation flag is low.
- R2: The load-product command (op code 0) writes the product of the two operands into the destination accumulator, sign-extended to 40 bits. With `signed_ops`=1 and `frac_mode`=0, both operands are sign-extended to 17 bits before multiplying.
- R3: With `signed_ops`=0, both operands are zero-extended to 17 bits, so 0xFFFF is treated as 65535.
- R4: With `frac_mode`=1, the product is doubled (shifted left by one) before it is used by the load-product and accumulate commands.
- R5: The accumulate command (op code 1) writes the destination accumulator plus the product, or the destination minus the product when `sub_en`=1.
- R6: The accumulator-add command (op code 2) writes the destination accumulator plus the `src_sel` accumulator, or the destination minus the `src_sel` accumulator when `sub_en`=1. Both values are taken as 40-bit signed.
- R7: The shift command (op code 3) moves the destination accumulator by the signed 6-bit `shamt`. A positive value shifts left and a negative value shifts right arithmetically. Magnitudes above 16 are treated as 16.
- R8: With `sat_en`=1, a result above 2^39-1 or below -2^39 is replaced by 0x7F_FFFF_FFFF or 0x80_0000_0000 respectively, and that accumulator's `sat_flag` bit sets. The bit stays set until reset.
- R9: With `sat_en`=0, an out-of-range result keeps its low 40 bits (wraps), and `sat_flag` does not change.
- R10: The `ovf_flag` bit of an accumulator is high exactly when bits 39..31 of that accumulator are not all equal, meaning the value no longer fits in 32 signed bits.
- R11: An accumulator changes only on a cycle with `op_valid`=1 whose `dst_sel` names it. Without `op_valid`, or when the other accumulator is selected, it keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| op_valid | input | 1 | Execute the command this cycle |
| op_sel | input | 2 | 0 load product, 1 accumulate, 2 accumulator add, 3 shift |
| dst_sel | input | 1 | Destination accumulator index |
| src_sel | input | 1 | Second accumulator for the add command |
| opnd_a | input | 16 | First multiplier operand |
| opnd_b | input | 16 | Second multiplier operand |
| signed_ops | input | 1 | 1 sign-extends the operands, 0 zero-extends them |
| frac_mode | input | 1 | 1 doubles the product (fractional format) |
| sub_en | input | 1 | Subtract instead of add for op codes 1 and 2 |
| sat_en | input | 1 | Clamp out-of-range results for this command |
| shamt | input | 6 | Signed shift amount; positive is left |
| acc_out | output | 80 | Accumulator 1 in bits 79..40, accumulator 0 in bits 39..0 |
| ovf_flag | output | 2 | Guard bits in use, one bit per accumulator |
| sat_flag | output | 2 | Sticky saturation, one bit per accumulator |

## Verification
Both accumulators are visible on the ports after every command. A wrong intermediate result therefore shows on `acc_out` at the first edge after the faulty command, not many operations later. A wrong sign or zero extension, a missing fractional doubling, or a lost guard bit would show as a wrong value in the destination accumulator in that same cycle. A write to the wrong accumulator would show as a change in the one that was not selected, again in that cycle. A fault in the clamp or the sticky flag could stay hidden until a result leaves the 40-bit range. For that reason the stimulus keeps pushing accumulators past both limits, with saturation both on and off.

// File: rtl/mac_pkg.sv
// Shared types for the multiply-accumulate engine.
// Assumes: the command code is two bits wide and every code is defined.
package mac_pkg;
    typedef enum logic [1:0] {
        OP_MPY = 2'd0,
        OP_MAC = 2'd1,
        OP_ADD = 2'd2,
        OP_SHF = 2'd3
    } mac_op_e;
endpackage

// File: rtl/mac_mult.sv
// 17x17 multiplier. Each operand is first extended by one bit, with its sign
// bit or with a zero, which gives one signed multiply for both formats.
// In fractional mode the product is doubled. The result is sign-extended to
// the accumulator width.
// Assumes: ACC_W >= 2*(OPND_W+1)+1, so the doubled product always fits.
module mac_mult #(
    parameter int OPND_W = 16,
    parameter int ACC_W  = 40
) (
    input  logic [OPND_W-1:0]       opnd_a,
    input  logic [OPND_W-1:0]       opnd_b,
    input  logic                    signed_ops,
    input  logic                    frac_mode,
    output logic signed [ACC_W-1:0] product
);
    localparam int EXT_W  = OPND_W + 1;
    localparam int PROD_W = 2 * EXT_W;

    logic signed [EXT_W-1:0]  ext_a;
    logic signed [EXT_W-1:0]  ext_b;
    logic signed [PROD_W-1:0] raw;
    logic signed [ACC_W-1:0]  wide;

    // Operand extension, multiply, and optional doubling.
    always_comb begin
        ext_a   = signed_ops ? $signed({opnd_a[OPND_W-1], opnd_a}) : $signed({1'b0, opnd_a});
        ext_b   = signed_ops ? $signed({opnd_b[OPND_W-1], opnd_b}) : $signed({1'b0, opnd_b});
        raw     = ext_a * ext_b;
        wide    = ACC_W'(raw);
        product = frac_mode ? (wide <<< 1) : wide;
    end

    // A zero operand must give a zero product in every format (R2, R3, R4).
    always_comb begin
        if (opnd_a == '0 || opnd_b == '0) begin
            assert_zero_product_R2: assert (product == '0);
        end
    end
endmodule

// File: rtl/mac_shift.sv
// Bidirectional barrel shifter for one accumulator value. A positive amount
// shifts left into a wider result, so no bits are lost before saturation. A
// negative amount shifts right arithmetically. The magnitude is clamped to
// SHIFT_MAX.
// Assumes: WIDE_W >= ACC_W + SHIFT_MAX.
module mac_shift #(
    parameter int ACC_W     = 40,
    parameter int SHIFT_MAX = 16,
    parameter int SH_W      = 6,
    parameter int WIDE_W    = 57
) (
    input  logic signed [ACC_W-1:0]  acc_in,
    input  logic [SH_W-1:0]          shamt,
    output logic signed [WIDE_W-1:0] shifted
);
    localparam logic [SH_W:0] MAG_MAX = (SH_W+1)'(SHIFT_MAX);

    logic                    go_right;
    logic [SH_W:0]           mag_raw;
    logic [SH_W:0]           mag;
    logic signed [WIDE_W-1:0] base;

    // Split the amount into direction and clamped magnitude, then shift.
    always_comb begin
        go_right = shamt[SH_W-1];
        mag_raw  = go_right ? (~{1'b1, shamt} + 1'b1) : {1'b0, shamt};
        mag      = (mag_raw > MAG_MAX) ? MAG_MAX : mag_raw;
        base     = WIDE_W'(acc_in);
        shifted  = go_right ? (base >>> mag) : (base <<< mag);
    end

    // A zero shift amount must pass the value through unchanged (R7).
    always_comb begin
        if (shamt == '0) begin
            assert_zero_shift_R7: assert (shifted == WIDE_W'(acc_in));
        end
    end
endmodule

// File: rtl/mac_sat.sv
// Reduces a wide signed result to accumulator width. When the value does not
// fit, it is clamped to the nearest limit if saturation is enabled, and
// otherwise truncated (wrapped). Reports whether a clamp took place.
// Assumes: WIDE_W > ACC_W.
module mac_sat #(
    parameter int ACC_W  = 40,
    parameter int WIDE_W = 57
) (
    input  logic signed [WIDE_W-1:0] wide_in,
    input  logic                     sat_en,
    output logic signed [ACC_W-1:0]  acc_res,
    output logic                     clamped
);
    localparam int HI_W = WIDE_W - ACC_W + 1;
    localparam logic [ACC_W-1:0] POS_LIM = {1'b0, {(ACC_W-1){1'b1}}};
    localparam logic [ACC_W-1:0] NEG_LIM = {1'b1, {(ACC_W-1){1'b0}}};

    logic [HI_W-1:0] hi;
    logic            fits;

    // Range test on the bits above the accumulator sign, then clamp or wrap.
    always_comb begin
        hi      = wide_in[WIDE_W-1:ACC_W-1];
        fits    = (&hi) || (~|hi);
        clamped = sat_en && !fits;
        if (clamped) begin
            acc_res = wide_in[WIDE_W-1] ? $signed(NEG_LIM) : $signed(POS_LIM);
        end else begin
            acc_res = wide_in[ACC_W-1:0];
        end
    end

    // A clamped result must be one of the two limits, on the side of the input's sign (R8).
    always_comb begin
        if (clamped) begin
            assert_clamp_limit_R8: assert ((wide_in[WIDE_W-1] && acc_res == $signed(NEG_LIM)) ||
                                           (!wide_in[WIDE_W-1] && acc_res == $signed(POS_LIM)));
        end
    end
endmodule

// File: rtl/dsp_mac_engine.sv
// Multiply-accumulate engine with NUM_ACC accumulators that have guard bits.
// Each valid command builds a wide result from the product, the destination
// accumulator and a second accumulator. The result is then reduced to
// accumulator width, with optional saturation, and written at the next edge.
// Guard-bit overflow flags are decoded from the stored accumulators. The
// saturation flags are sticky until reset.
// Assumes: synchronous active-low reset; all command inputs are qualified by op_valid.
module dsp_mac_engine #(
    parameter int OPND_W    = 16,
    parameter int ACC_W     = 40,
    parameter int GUARD_W   = 8,
    parameter int SHIFT_MAX = 16,
    parameter int SH_W      = 6,
    parameter int NUM_ACC   = 2,
    parameter int ASEL_W    = (NUM_ACC > 1) ? $clog2(NUM_ACC) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     op_valid,
    input  logic [1:0]               op_sel,
    input  logic [ASEL_W-1:0]        dst_sel,
    input  logic [ASEL_W-1:0]        src_sel,
    input  logic [OPND_W-1:0]        opnd_a,
    input  logic [OPND_W-1:0]        opnd_b,
    input  logic                     signed_ops,
    input  logic                     frac_mode,
    input  logic                     sub_en,
    input  logic                     sat_en,
    input  logic [SH_W-1:0]          shamt,
    output logic [NUM_ACC*ACC_W-1:0] acc_out,
    output logic [NUM_ACC-1:0]       ovf_flag,
    output logic [NUM_ACC-1:0]       sat_flag
);
    import mac_pkg::*;

    localparam int WIDE_W = ACC_W + SHIFT_MAX + 1;
    localparam int LOW_W  = ACC_W - GUARD_W;

    logic signed [ACC_W-1:0]  acc_q [NUM_ACC];
    logic [NUM_ACC-1:0]       sat_q;
    logic signed [ACC_W-1:0]  product;
    logic signed [WIDE_W-1:0] shifted;
    logic signed [WIDE_W-1:0] dst_w;
    logic signed [WIDE_W-1:0] src_w;
    logic signed [WIDE_W-1:0] prod_w;
    logic signed [WIDE_W-1:0] cand;
    logic signed [ACC_W-1:0]  acc_res;
    logic                     clamped;
    mac_op_e                  op;

    mac_mult #(.OPND_W(OPND_W), .ACC_W(ACC_W)) u_mult (
        .opnd_a     (opnd_a),
        .opnd_b     (opnd_b),
        .signed_ops (signed_ops),
        .frac_mode  (frac_mode),
        .product    (product)
    );

    mac_shift #(.ACC_W(ACC_W), .SHIFT_MAX(SHIFT_MAX), .SH_W(SH_W), .WIDE_W(WIDE_W)) u_shift (
        .acc_in  (acc_q[dst_sel]),
        .shamt   (shamt),
        .shifted (shifted)
    );

    // Choose the wide candidate result for the command.
    always_comb begin
        op     = mac_op_e'(op_sel);
        dst_w  = WIDE_W'(acc_q[dst_sel]);
        src_w  = WIDE_W'(acc_q[src_sel]);
        prod_w = WIDE_W'(product);
        case (op)
            OP_MPY:  cand = prod_w;
            OP_MAC:  cand = sub_en ? (dst_w - prod_w) : (dst_w + prod_w);
            OP_ADD:  cand = sub_en ? (dst_w - src_w) : (dst_w + src_w);
            OP_SHF:  cand = shifted;
            default: cand = dst_w;
        endcase
    end

    mac_sat #(.ACC_W(ACC_W), .WIDE_W(WIDE_W)) u_sat (
        .wide_in (cand),
        .sat_en  (sat_en),
        .acc_res (acc_res),
        .clamped (clamped)
    );

    // Accumulator and sticky saturation registers; only the selected one is written.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < NUM_ACC; k++) begin
                acc_q[k] <= '0;
            end
            sat_q <= '0;
        end else if (op_valid) begin
            for (int k = 0; k < NUM_ACC; k++) begin
                if (dst_sel == ASEL_W'(k)) begin
                    acc_q[k] <= acc_res;
                    sat_q[k] <= sat_q[k] | clamped;
                end
            end
        end
    end

    assign sat_flag = sat_q;

    generate
        for (genvar i = 0; i < NUM_ACC; i++) begin : g_acc
            // Drive this accumulator's output slice and its guard-bit flag.
            assign acc_out[i*ACC_W +: ACC_W] = acc_q[i];
            assign ovf_flag[i] = !((&acc_q[i][ACC_W-1:LOW_W-1]) || (~|acc_q[i][ACC_W-1:LOW_W-1]));

            // An accumulator that is not written keeps its value (R11).
            assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
                !(op_valid && dst_sel == ASEL_W'(i)) |=> $stable(acc_out[i*ACC_W +: ACC_W]));

            // Once set, the saturation flag stays set until reset (R8).
            assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
                sat_flag[i] |=> sat_flag[i]);

            // A command without saturation never raises the flag (R9).
            assert_no_sat_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
                (op_valid && !sat_en && dst_sel == ASEL_W'(i) && !sat_flag[i]) |=> !sat_flag[i]);

            // Loading a product of a zero operand clears the destination (R2).
            assert_mpy_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
                (op_valid && op_sel == 2'd0 && dst_sel == ASEL_W'(i) && opnd_a == '0)
                |=> (acc_out[i*ACC_W +: ACC_W] == '0) && !ovf_flag[i]);
        end
    endgenerate
endmodule

// File: tb/dsp_mac_engine_bench.sv
`timescale 1ns/1ps
module dsp_mac_engine_bench;
    localparam longint POS_LIM = 64'sd549755813887;
    localparam longint NEG_LIM = -64'sd549755813888;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        op_valid;
    logic [1:0]  op_sel;
    logic        dst_sel, src_sel;
    logic [15:0] opnd_a, opnd_b;
    logic        signed_ops, frac_mode, sub_en, sat_en;
    logic [5:0]  shamt;
    logic [79:0] acc_out;
    logic [1:0]  ovf_flag, sat_flag;

    int     checks = 0;
    int     fails  = 0;
    bit     done   = 0;
    longint acc_m [2];
    bit     sat_m [2];

    always #4 clk = ~clk;

    dsp_mac_engine u_dsp_mac_engine (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
        .dst_sel(dst_sel), .src_sel(src_sel), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .signed_ops(signed_ops), .frac_mode(frac_mode), .sub_en(sub_en),
        .sat_en(sat_en), .shamt(shamt), .acc_out(acc_out),
        .ovf_flag(ovf_flag), .sat_flag(sat_flag)
    );

    function automatic longint acc_act(int i);
        logic [39:0] v;
        v = acc_out[i*40 +: 40];
        return longint'($signed(v));
    endfunction

    function automatic longint ref_prod(logic [15:0] a, logic [15:0] b, bit sgn, bit frac);
        longint ea, eb, p;
        ea = sgn ? longint'($signed(a)) : longint'({48'd0, a});
        eb = sgn ? longint'($signed(b)) : longint'({48'd0, b});
        p  = ea * eb;
        return frac ? p * 2 : p;
    endfunction

    function automatic longint ref_shift(longint v, logic [5:0] sh);
        int s;
        s = int'($signed(sh));
        if (s > 16) s = 16;
        if (s < -16) s = -16;
        return (s >= 0) ? (v <<< s) : (v >>> (-s));
    endfunction

    function automatic longint wrap40(longint v);
        logic [63:0] u;
        u = v;
        return longint'($signed(u[39:0]));
    endfunction

    task automatic check(string req, longint act, longint exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_all(string req);
        for (int i = 0; i < 2; i++) begin
            check(req, acc_act(i), acc_m[i]);
            check({req, "/R10 ovf"}, longint'(ovf_flag[i]),
                  longint'(longint'(int'(acc_m[i])) != acc_m[i]));
            check({req, "/R8 sat"}, longint'(sat_flag[i]), longint'(sat_m[i]));
        end
    endtask

    // Drive one command, let it commit at the next edge, update the model, compare.
    task automatic run_op(logic [1:0] op, bit dst, bit src, logic [15:0] a, logic [15:0] b,
                          bit sgn, bit frac, bit sub, bit sat, logic [5:0] sh, string req);
        longint d, w;
        @(negedge clk);
        op_valid = 1'b1; op_sel = op; dst_sel = dst; src_sel = src;
        opnd_a = a; opnd_b = b; signed_ops = sgn; frac_mode = frac;
        sub_en = sub; sat_en = sat; shamt = sh;
        @(posedge clk);
        #1;
        op_valid = 1'b0;
        d = acc_m[dst];
        case (op)
            2'd0:    w = ref_prod(a, b, sgn, frac);
            2'd1:    w = sub ? d - ref_prod(a, b, sgn, frac) : d + ref_prod(a, b, sgn, frac);
            2'd2:    w = sub ? d - acc_m[src] : d + acc_m[src];
            default: w = ref_shift(d, sh);
        endcase
        if (w > POS_LIM || w < NEG_LIM) begin
            if (sat) begin
                w = (w > POS_LIM) ? POS_LIM : NEG_LIM;
                sat_m[dst] = 1'b1;
            end else begin
                w = wrap40(w);
            end
        end
        acc_m[dst] = w;
        check_all(req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int unsigned seed_val;
        seed_val = $urandom(32'h5A17);
        rst_n = 1'b0; op_valid = 1'b0; op_sel = 2'd0; dst_sel = 1'b0; src_sel = 1'b0;
        opnd_a = '0; opnd_b = '0; signed_ops = 1'b1; frac_mode = 1'b0;
        sub_en = 1'b0; sat_en = 1'b0; shamt = '0;
        acc_m[0] = 0; acc_m[1] = 0; sat_m[0] = 0; sat_m[1] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check_all("R1 reset");

        // R2: signed integer product
        run_op(2'd0, 0, 0, 16'hFFFD, 16'd7, 1, 0, 0, 0, 6'd0, "R2 mpy");
        check("R2 literal", acc_act(0), -21);
        // R3: unsigned operands are zero-extended
        run_op(2'd0, 1, 0, 16'hFFFF, 16'd2, 0, 0, 0, 0, 6'd0, "R3 unsigned");
        check("R3 literal", acc_act(1), 131070);
        // R4: fractional doubling, including -1.0 * -1.0 reaching the guard bits (R10)
        run_op(2'd0, 0, 0, 16'h4000, 16'h4000, 1, 1, 0, 0, 6'd0, "R4 frac");
        check("R4 literal", acc_act(0), 64'sd536870912);
        run_op(2'd0, 0, 0, 16'h8000, 16'h8000, 1, 1, 0, 0, 6'd0, "R4 frac minus one");
        check("R10 guard in use", longint'(ovf_flag[0]), 1);
        // R5: accumulate and subtract-accumulate
        run_op(2'd1, 1, 0, 16'd100, 16'd3, 1, 0, 0, 0, 6'd0, "R5 mac add");
        run_op(2'd1, 1, 0, 16'd50, 16'd4, 1, 0, 1, 0, 6'd0, "R5 mac sub");
        check("R5 literal", acc_act(1), 131070 + 300 - 200);
        // R6: accumulator add and subtract
        run_op(2'd2, 1, 0, 16'd0, 16'd0, 1, 0, 0, 0, 6'd0, "R6 add");
        run_op(2'd2, 0, 1, 16'd0, 16'd0, 1, 0, 1, 0, 6'd0, "R6 sub");
        // R7: left, right and clamped shifts
        run_op(2'd0, 0, 0, 16'hFF00, 16'd1, 1, 0, 0, 0, 6'd0, "R2 reload");
        run_op(2'd3, 0, 0, 16'd0, 16'd0, 1, 0, 0, 0, 6'd4, "R7 left");
        check("R7 literal left", acc_act(0), -4096);
        run_op(2'd3, 0, 0, 16'd0, 16'd0, 1, 0, 0, 0, 6'h3E, "R7 right");
        check("R7 literal right", acc_act(0), -1024);
        run_op(2'd3, 0, 0, 16'd0, 16'd0, 1, 0, 0, 0, 6'd31, "R7 clamp left");
        check("R7 literal clamp", acc_act(0), -1024 * 65536);
        run_op(2'd3, 0, 0, 16'd0, 16'd0, 1, 0, 0, 0, 6'h20, "R7 clamp right");
        // R8: saturation on positive and negative overflow
        run_op(2'd0, 0, 0, 16'h7FFF, 16'h7FFF, 1, 0, 0, 1, 6'd0, "R8 setup");
        run_op(2'd3, 0, 0, 16'd0, 16'd0, 1, 0, 0, 1, 6'd16, "R8 clamp pos");
        check("R8 literal pos", acc_act(0), POS_LIM);
        check("R8 flag", longint'(sat_flag[0]), 1);
        run_op(2'd0, 0, 0, 16'd1, 16'd1, 1, 0, 0, 0, 6'd0, "R8 sticky");
        check("R8 sticky literal", longint'(sat_flag[0]), 1);
        // R9: wrap without saturation on accumulator 1
        run_op(2'd0, 1, 0, 16'h8000, 16'h7FFF, 1, 0, 0, 0, 6'd0, "R9 setup");
        run_op(2'd3, 1, 0, 16'd0, 16'd0, 1, 0, 0, 0, 6'd16, "R9 wrap");
        check("R9 flag stays low", longint'(sat_flag[1]), 0);
        run_op(2'd0, 1, 0, 16'h8000, 16'h7FFF, 1, 0, 0, 1, 6'd0, "R8 setup neg");
        run_op(2'd3, 1, 0, 16'd0, 16'd0, 1, 0, 0, 1, 6'd16, "R8 clamp neg");
        check("R8 literal neg", acc_act(1), NEG_LIM);
        // R11: idle cycles leave everything unchanged
        repeat (5) @(posedge clk);
        #1;
        check_all("R11 idle");

        // Constrained random mix across all commands and modes
        for (int k = 0; k < 600; k++) begin
            logic [1:0] op;
            int sh;
            string tag;
            op = 2'($urandom_range(0, 3));
            sh = int'($urandom_range(0, 44)) - 22;
            case (op)
                2'd0:    tag = "R2 rnd";
                2'd1:    tag = "R5 rnd";
                2'd2:    tag = "R6 rnd";
                default: tag = "R7 rnd";
            endcase
            run_op(op, 1'($urandom), 1'($urandom), 16'($urandom), 16'($urandom),
                   1'($urandom), 1'($urandom), 1'($urandom),
                   ($urandom_range(0, 3) != 0), 6'(sh), tag);
            if ((k % 50) == 49) begin
                repeat (2) @(posedge clk);
                #1;
                check_all("R11 rnd idle");
            end
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule